// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block is the hazard-control unit of a five-stage, in-order integer pipeline with stages fetch, decode, execute, memory and writeback, separated by pipeline registers. Every cycle it compares the source registers of the instruction in decode with the destination registers held in the three later pipeline registers. From that comparison it decides whether to freeze fetch and decode while a bubble enters execute, and how each operand is steered.

Branches are compared and resolved in decode. The block therefore also drives the operand selects of the decode-stage comparator, besides the selects of the execute-stage operand multiplexers. A static mode input picks between two schemes. The first only stalls and relies on a register file that writes in the first half of a cycle and reads in the second half. The second bypasses results and stalls only when a value cannot exist yet.

The execute-stage selects are worked out while the consumer is in decode and then registered, so they line up with that instruction when it reaches execute. Operand select encoding: 0 means the register-file value, 1 the ALU result held in the execute/memory register, and 2 the writeback value held in the memory/writeback register.

Top module: `hazard_ctrl`

## Requirements
- R1: After reset both execute-stage selects read 0 (register file), and the stall outputs stay low while no source matches a later destination.
- R2: In stall-only mode, a consumer directly behind its producer is held two cycles, so it decodes in the producer's writeback cycle. A two-instruction pair finishes writeback in cycle 8.
- R3: In stall-only mode, a consumer two instructions behind its producer is held one cycle.
- R4: A source of register 0, a source that is not used, or a destination whose write-enable is low never causes a stall or a bypass.
- R5: In bypass mode, an ALU result feeding the very next ALU operand or store-data operand causes no stall. That operand's execute select is 1, and the pair finishes writeback in cycle 6.
- R6: In bypass mode, a producer two instructions ahead gives execute select 2. When both the execute/memory and the memory/writeback destinations match, select 1 wins.
- R7: In bypass mode, a load directly followed by a user of its result inserts exactly one bubble. The user's execute select is then 2.
- R8: In bypass mode, a branch needing an ALU result still in execute stalls one cycle, then takes comparator select 1.
- R9: In bypass mode, a branch needing a load result still in execute stalls two cycles, then takes comparator select 0.
- R10: In stall-only mode every comparator and execute select is 0. A branch behind its producer is held two cycles.
- R11: While stalled, the PC hold, the fetch/decode hold and the bubble output are all high. The execute selects of the bubble that follows are 0.
- R12: Each execute-stage select becomes visible in the cycle after its instruction leaves decode, and it stays the same for that instruction's cycle in execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass_en | input | 1 | Static mode: 0 stall-only, 1 bypassing |
| id_rs | input | REG_AW | First source register of the decode instruction |
| id_rs_used | input | 1 | First source is read |
| id_rt | input | REG_AW | Second source (store data) of the decode instruction |
| id_rt_used | input | 1 | Second source is read |
| id_branch | input | 1 | Decode instruction is a branch compared in decode |
| ex_rd | input | REG_AW | Destination in the decode/execute register |
| ex_wen | input | 1 | That destination is written |
| ex_load | input | 1 | That instruction is a load |
| mem_rd | input | REG_AW | Destination in the execute/memory register |
| mem_wen | input | 1 | That destination is written |
| mem_load | input | 1 | That instruction is a load |
| wb_rd | input | REG_AW | Destination in the memory/writeback register |
| wb_wen | input | 1 | That destination is written |
| pc_hold | output | 1 | Keep the PC |
| ifid_hold | output | 1 | Keep the fetch/decode register |
| idex_bubble | output | 1 | Load a no-op into decode/execute |
| id_sel_a | output | 2 | Comparator select, first source |
| id_sel_b | output | 2 | Comparator select, second source |
| ex_sel_a | output | 2 | Execute operand select, first source |
| ex_sel_b | output | 2 | Execute operand select, second source |

## Verification
The bench builds the block with the default register-address width of 5. Random programs are drawn only from registers 0 to 3, with every mix of loads, stores, branches and disabled writes. This makes distance-one and distance-two matches, double matches that test priority, and register-0 writes common in both modes. Directed short programs run in a modelled pipeline that is advanced by the expected stall. They check the exact completion cycles and stall counts, and the select values seen by the dependent instruction.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FW_RF    = 2'd0,
    FW_EXMEM = 2'd1,
    FW_MEMWB = 2'd2
  } fwd_sel_e;
endpackage

// File: rtl/hz_src_eval.sv
module hz_src_eval
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              bypass_en,
  input  logic              is_branch,
  input  logic [REG_AW-1:0] src,
  input  logic              src_used,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_wen,
  input  logic              ex_load,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wen,
  input  logic              mem_load,
  output logic              need_stall,
  output fwd_sel_e          ex_sel_nxt,
  output fwd_sel_e          id_sel
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic live, hit_ex, hit_mem;

  always_comb begin
    live    = src_used && (src != ZERO_REG);
    hit_ex  = live && ex_wen  && (ex_rd  == src);
    hit_mem = live && mem_wen && (mem_rd == src);

    if (!bypass_en)     need_stall = hit_ex || hit_mem;
    else if (is_branch) need_stall = hit_ex || (hit_mem && mem_load);
    else                need_stall = hit_ex && ex_load;

    if (bypass_en && hit_ex)       ex_sel_nxt = FW_EXMEM;
    else if (bypass_en && hit_mem) ex_sel_nxt = FW_MEMWB;
    else                           ex_sel_nxt = FW_RF;

    if (bypass_en && is_branch && hit_mem && !mem_load) id_sel = FW_EXMEM;
    else                                                id_sel = FW_RF;
  end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bypass_en,
  input  logic [REG_AW-1:0] id_rs,
  input  logic              id_rs_used,
  input  logic [REG_AW-1:0] id_rt,
  input  logic              id_rt_used,
  input  logic              id_branch,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_wen,
  input  logic              ex_load,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wen,
  input  logic              mem_load,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_wen,
  output logic              pc_hold,
  output logic              ifid_hold,
  output logic              idex_bubble,
  output logic [1:0]        id_sel_a,
  output logic [1:0]        id_sel_b,
  output logic [1:0]        ex_sel_a,
  output logic [1:0]        ex_sel_b
);
  localparam int NSRC = 2;

  logic [REG_AW-1:0] src_num  [NSRC];
  logic              src_used [NSRC];
  logic     [NSRC-1:0] src_stall;
  fwd_sel_e          sel_nxt  [NSRC];
  fwd_sel_e          sel_id   [NSRC];
  fwd_sel_e          sel_q    [NSRC];
  fwd_sel_e          sel_d    [NSRC];
  logic              stall;
  logic              wb_unused;

  assign src_num[0]  = id_rs;
  assign src_num[1]  = id_rt;
  assign src_used[0] = id_rs_used;
  assign src_used[1] = id_rt_used;

  // writeback matches resolve through the split-cycle register file
  assign wb_unused = ^{wb_rd, wb_wen};

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hz_src_eval #(.REG_AW(REG_AW)) u_eval (
      .bypass_en  (bypass_en),
      .is_branch  (id_branch),
      .src        (src_num[g]),
      .src_used   (src_used[g]),
      .ex_rd      (ex_rd),
      .ex_wen     (ex_wen),
      .ex_load    (ex_load),
      .mem_rd     (mem_rd),
      .mem_wen    (mem_wen),
      .mem_load   (mem_load),
      .need_stall (src_stall[g]),
      .ex_sel_nxt (sel_nxt[g]),
      .id_sel     (sel_id[g])
    );

    always_comb begin
      sel_d[g] = stall ? FW_RF : sel_nxt[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q[g] <= FW_RF;
      else        sel_q[g] <= sel_d[g];
    end
  end

  assign stall       = |src_stall;
  assign pc_hold     = stall;
  assign ifid_hold   = stall;
  assign idex_bubble = stall;
  assign id_sel_a    = sel_id[0];
  assign id_sel_b    = sel_id[1];
  assign ex_sel_a    = sel_q[0];
  assign ex_sel_b    = sel_q[1];
endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk #(
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bypass_en,
  input logic [REG_AW-1:0] id_rs,
  input logic              id_branch,
  input logic              ex_load,
  input logic              pc_hold,
  input logic              idex_bubble,
  input logic [1:0]        id_sel_a,
  input logic [1:0]        id_sel_b,
  input logic [1:0]        ex_sel_a,
  input logic [1:0]        ex_sel_b
);
  // R11: a bubble carries no bypass into execute
  assert_bubble_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |=> (ex_sel_a == 2'd0 && ex_sel_b == 2'd0));

  // R10: stall-only mode never steers the comparator
  assert_stallmode_id_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass_en |-> (id_sel_a == 2'd0 && id_sel_b == 2'd0));

  // R10: stall-only mode never steers execute operands
  assert_stallmode_ex_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass_en |=> (ex_sel_a == 2'd0 && ex_sel_b == 2'd0));

  // R4: register 0 is never bypassed into the comparator
  assert_zero_reg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rs == '0) |-> (id_sel_a == 2'd0));

  // R5: bypass mode holds only for a load in execute or a branch
  assert_no_alu_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_en && !id_branch && !ex_load) |-> !pc_hold);

  // R8: the comparator never takes the writeback path
  assert_id_sel_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (id_sel_a != 2'd2 && id_sel_b != 2'd2));
endmodule

bind hazard_ctrl hazard_ctrl_chk #(.REG_AW(REG_AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bypass_en   (bypass_en),
  .id_rs       (id_rs),
  .id_branch   (id_branch),
  .ex_load     (ex_load),
  .pc_hold     (pc_hold),
  .idex_bubble (idex_bubble),
  .id_sel_a    (id_sel_a),
  .id_sel_b    (id_sel_b),
  .ex_sel_a    (ex_sel_a),
  .ex_sel_b    (ex_sel_b)
);

// File: tb/hazard_ctrl_tb_top.sv
module hazard_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;

  typedef struct packed {
    logic          v;
    logic [7:0]    idx;
    logic [AW-1:0] rd, rs, rt;
    logic          wen, ld, ru, tu, br;
    logic [1:0]    ea, eb;
  } ins_t;

  logic clk, rst_n, bypass_en;
  logic [AW-1:0] id_rs, id_rt, ex_rd, mem_rd, wb_rd;
  logic id_rs_used, id_rt_used, id_branch, ex_wen, ex_load, mem_wen, mem_load, wb_wen;
  logic pc_hold, ifid_hold, idex_bubble;
  logic [1:0] id_sel_a, id_sel_b, ex_sel_a, ex_sel_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  hazard_ctrl #(.REG_AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bypass_en(bypass_en),
    .id_rs(id_rs), .id_rs_used(id_rs_used), .id_rt(id_rt), .id_rt_used(id_rt_used),
    .id_branch(id_branch), .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load),
    .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_load(mem_load),
    .wb_rd(wb_rd), .wb_wen(wb_wen),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
    .id_sel_a(id_sel_a), .id_sel_b(id_sel_b), .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic hit(logic [AW-1:0] s, logic u, logic [AW-1:0] d, logic w);
    return u && (s != 0) && w && (d == s);
  endfunction

  function automatic logic ref_stall(logic byp, ins_t i, ins_t e, ins_t m);
    logic st = 0;
    logic he, hm;
    for (int k = 0; k < 2; k++) begin
      he = hit(k == 0 ? i.rs : i.rt, k == 0 ? i.ru : i.tu, e.rd, e.wen);
      hm = hit(k == 0 ? i.rs : i.rt, k == 0 ? i.ru : i.tu, m.rd, m.wen);
      if (!byp)      st |= he | hm;
      else if (i.br) st |= he | (hm & m.ld);
      else           st |= he & e.ld;
    end
    return st;
  endfunction

  function automatic logic [1:0] ref_exsel(logic byp, logic [AW-1:0] s, logic u, ins_t e, ins_t m);
    if (!byp) return 2'd0;
    if (hit(s, u, e.rd, e.wen)) return 2'd1;
    if (hit(s, u, m.rd, m.wen)) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [1:0] ref_idsel(logic byp, logic [AW-1:0] s, logic u, logic br, ins_t m);
    return (byp && br && hit(s, u, m.rd, m.wen) && !m.ld) ? 2'd1 : 2'd0;
  endfunction

  function automatic ins_t mk(int idx, int rd, int rs, int rt, bit wen, bit ld, bit ru, bit tu, bit br);
    ins_t x;
    x.v = 1; x.idx = 8'(idx); x.rd = AW'(rd); x.rs = AW'(rs); x.rt = AW'(rt);
    x.wen = wen; x.ld = ld; x.ru = ru; x.tu = tu; x.br = br; x.ea = 0; x.eb = 0;
    return x;
  endfunction

  ins_t prog [64];
  logic [1:0] obs_a [64];
  logic [1:0] obs_b [64];
  logic [1:0] obs_id;
  int stalls, finish_cycle;

  // Runs prog[0..n-1] in a modelled pipeline advanced by the expected stall.
  task automatic run(input bit byp, input int n);
    ins_t id_s = '0, ex_s = '0, mem_s = '0, wb_s = '0;
    int pc = 0, step = 0;
    logic st;
    bypass_en = byp;
    stalls = 0; finish_cycle = 0; obs_id = 0;
    if (n > 0) begin id_s = prog[0]; pc = 1; end
    while (!(wb_s.v && wb_s.idx == 8'(n-1)) && step < 2000) begin
      @(negedge clk);
      step++;
      id_rs = id_s.rs; id_rt = id_s.rt; id_rs_used = id_s.ru; id_rt_used = id_s.tu;
      id_branch = id_s.br;
      ex_rd = ex_s.rd; ex_wen = ex_s.wen; ex_load = ex_s.ld;
      mem_rd = mem_s.rd; mem_wen = mem_s.wen; mem_load = mem_s.ld;
      wb_rd = wb_s.rd; wb_wen = wb_s.wen;
      #1;
      st = ref_stall(byp, id_s, ex_s, mem_s);
      chk(pc_hold == st && ifid_hold == st && idex_bubble == st, "R11 stall outputs",
          {pc_hold, ifid_hold, idex_bubble}, {st, st, st});
      chk(id_sel_a == ref_idsel(byp, id_s.rs, id_s.ru, id_s.br, mem_s) &&
          id_sel_b == ref_idsel(byp, id_s.rt, id_s.tu, id_s.br, mem_s), "R8 comparator select",
          {id_sel_a, id_sel_b},
          {ref_idsel(byp, id_s.rs, id_s.ru, id_s.br, mem_s), ref_idsel(byp, id_s.rt, id_s.tu, id_s.br, mem_s)});
      chk(ex_sel_a == ex_s.ea && ex_sel_b == ex_s.eb, "R12 execute select",
          {ex_sel_a, ex_sel_b}, {ex_s.ea, ex_s.eb});
      if (ex_s.v) begin obs_a[ex_s.idx] = ex_sel_a; obs_b[ex_s.idx] = ex_sel_b; end
      if (id_s.v && id_s.br && !st) obs_id = id_sel_a;
      if (st) stalls++;
      wb_s = mem_s; mem_s = ex_s;
      if (st) ex_s = '0;
      else begin
        ex_s = id_s;
        ex_s.ea = ref_exsel(byp, id_s.rs, id_s.ru, ex_s.v ? mem_s : '0, mem_s);
        ex_s.ea = ref_exsel(byp, id_s.rs, id_s.ru, mem_s, wb_s);
        ex_s.eb = ref_exsel(byp, id_s.rt, id_s.tu, mem_s, wb_s);
        if (pc < n) begin id_s = prog[pc]; pc++; end
        else id_s = '0;
      end
      if (wb_s.v && wb_s.idx == 8'(n-1)) finish_cycle = step + 2;
    end
    // flush
    id_s = '0;
    @(negedge clk);
    {id_rs_used, id_rt_used, id_branch, ex_wen, ex_load, mem_wen, mem_load, wb_wen} = '0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; bypass_en = 0;
    {id_rs, id_rt, ex_rd, mem_rd, wb_rd} = '0;
    {id_rs_used, id_rt_used, id_branch, ex_wen, ex_load, mem_wen, mem_load, wb_wen} = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(ex_sel_a == 0 && ex_sel_b == 0, "R1 reset selects", {ex_sel_a, ex_sel_b}, 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!pc_hold && ex_sel_a == 0, "R1 idle no stall", {pc_hold, ex_sel_a}, 0);

    // R2: ADD r3 ; SUB r4 <- r3,r5 in stall-only mode
    prog[0] = mk(0, 3, 2, 1, 1, 0, 1, 1, 0);
    prog[1] = mk(1, 4, 3, 5, 1, 0, 1, 1, 0);
    run(0, 2);
    chk(stalls == 2, "R2 stall count", stalls, 2);
    chk(finish_cycle == 8, "R2 completion cycle", finish_cycle, 8);

    // R3: distance two in stall-only mode
    prog[1] = mk(1, 7, 8, 9, 1, 0, 1, 1, 0);
    prog[2] = mk(2, 4, 3, 5, 1, 0, 1, 1, 0);
    run(0, 3);
    chk(stalls == 1, "R3 stall count", stalls, 1);

    // R4: register 0 and write-disabled producers
    prog[0] = mk(0, 0, 2, 1, 1, 0, 1, 1, 0);
    prog[1] = mk(1, 4, 0, 0, 1, 0, 1, 1, 0);
    run(0, 2);
    chk(stalls == 0, "R4 zero register", stalls, 0);
    prog[0] = mk(0, 3, 2, 1, 0, 0, 1, 1, 0);
    prog[1] = mk(1, 4, 3, 3, 1, 0, 1, 1, 0);
    run(1, 2);
    chk(stalls == 0 && obs_a[1] == 0, "R4 write disabled", {stalls, obs_a[1]}, 0);

    // R5: bypass ALU->ALU and ALU->store data
    prog[0] = mk(0, 3, 2, 1, 1, 0, 1, 1, 0);
    prog[1] = mk(1, 4, 3, 5, 1, 0, 1, 1, 0);
    run(1, 2);
    chk(stalls == 0 && obs_a[1] == 1, "R5 alu bypass", {stalls, obs_a[1]}, 1);
    chk(finish_cycle == 6, "R5 completion cycle", finish_cycle, 6);
    prog[1] = mk(1, 0, 4, 3, 0, 0, 1, 1, 0);
    run(1, 2);
    chk(stalls == 0 && obs_b[1] == 1, "R5 store data bypass", {stalls, obs_b[1]}, 1);

    // R6: distance two and priority
    prog[1] = mk(1, 7, 8, 9, 1, 0, 1, 1, 0);
    prog[2] = mk(2, 4, 3, 5, 1, 0, 1, 1, 0);
    run(1, 3);
    chk(obs_a[2] == 2, "R6 distance two", obs_a[2], 2);
    prog[1] = mk(1, 3, 8, 9, 1, 0, 1, 1, 0);
    run(1, 3);
    chk(obs_a[2] == 1, "R6 newest wins", obs_a[2], 1);

    // R7: load-use
    prog[0] = mk(0, 4, 3, 0, 1, 1, 1, 0, 0);
    prog[1] = mk(1, 5, 4, 3, 1, 0, 1, 1, 0);
    run(1, 2);
    chk(stalls == 1 && obs_a[1] == 2, "R7 load use", {stalls, obs_a[1]}, {32'd1, 2'd2});

    // R8: branch behind ALU result
    prog[0] = mk(0, 3, 2, 1, 1, 0, 1, 1, 0);
    prog[1] = mk(1, 0, 3, 5, 0, 0, 1, 1, 1);
    run(1, 2);
    chk(stalls == 1 && obs_id == 1, "R8 branch after alu", {stalls, obs_id}, {32'd1, 2'd1});

    // R9: branch behind load
    prog[0] = mk(0, 3, 2, 0, 1, 1, 1, 0, 0);
    run(1, 2);
    chk(stalls == 2 && obs_id == 0, "R9 branch after load", {stalls, obs_id}, {32'd2, 2'd0});

    // R10: branch in stall-only mode
    prog[0] = mk(0, 3, 2, 1, 1, 0, 1, 1, 0);
    run(0, 2);
    chk(stalls == 2 && obs_id == 0, "R10 stall-only branch", {stalls, obs_id}, {32'd2, 2'd0});

    // Random programs over registers 0..3 (R11, R12)
    void'($urandom(32'h5eed_1234));
    for (int r = 0; r < 40; r++) begin
      for (int k = 0; k < 64; k++) begin
        int kind = $urandom_range(0, 3);
        prog[k] = mk(k, $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                     kind != 2 && kind != 3 ? 1'($urandom_range(0, 7) != 0) : 1'b0,
                     kind == 1, 1'($urandom_range(0, 5) != 0), 1'($urandom_range(0, 1)),
                     kind == 3);
      end
      run(1'(r % 2), 64);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule